// File: doc/BRIEF.md
# Buffered Timer Compare Channel

This block is one compare channel of a timer. Every clock it checks a free-running counter value, supplied by the counter block, against an active compare register. On equality it raises a sticky match flag for the interrupt logic. It also drives a waveform pin according to a 2-bit action code: set the pin, clear it, toggle it, or leave it alone.

The compare value is written through a shadow buffer. When the timer runs a PWM waveform, a write lands only in the shadow buffer. The counter block then signals either the TOP or the BOTTOM of the count, as chosen by a select input, and at that boundary the buffer is copied into the active register. This keeps the pulse widths clean and symmetric. In the plain counting and clear-on-match modes the buffer is bypassed and a write takes effect at once.

A force strobe makes the pin act as if a match had happened. It does not touch the flag or the counter, and it only works outside PWM operation.

Top module: `ocu_channel`

## Requirements
- R1: With `pwm_mode`=1, a write is held in the shadow buffer. The active register takes the buffer content only at a clock where `at_top`=1 (if `upd_at_top`=1) or `at_bottom`=1 (if `upd_at_top`=0). The other strobe has no effect.
- R2: With `pwm_mode`=0, a write sets `cmp_active` at the next clock edge. The shadow buffer takes the same value.
- R3: The active register never changes except by a write (R2) or a boundary commit (R1). Counter strobes outside PWM mode leave it unchanged.
- R4: The channel compares all bits of `cnt_val` with the active register every clock. Equality sets `match_flag` at the following clock edge.
- R5: `flag_clr`=1 clears `match_flag` at the next edge. If a match occurs in the same cycle, the flag is set instead.
- R6: The action code `out_mode` sets the pin's response at the edge after a match: 2'b01 toggles `wave_out`, 2'b10 clears it, and 2'b11 sets it.
- R7: With `out_mode`=2'b00 the pin logic is disconnected and `wave_out` holds its value, even on a match or a force.
- R8: With `pwm_mode`=0, `force_cmp`=1 updates `wave_out` at the next edge as a match would. It does not set `match_flag`.
- R9: With `pwm_mode`=1, `force_cmp` is ignored and `wave_out` keeps its value.
- R10: Synchronous reset clears the active register, the shadow buffer, `match_flag` and `wave_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Counter value from the counter block |
| at_top | input | 1 | Counter is at TOP this cycle |
| at_bottom | input | 1 | Counter is at BOTTOM this cycle |
| upd_at_top | input | 1 | 1: commit at TOP, 0: commit at BOTTOM |
| pwm_mode | input | 1 | 1 when a PWM waveform mode is active |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value written |
| out_mode | input | 2 | Pin action code on a match |
| force_cmp | input | 1 | Force-match strobe |
| flag_clr | input | 1 | Write-one-to-clear for the match flag |
| match_flag | output | 1 | Sticky match interrupt flag |
| wave_out | output | 1 | Waveform pin |
| cmp_active | output | CNT_W | Active compare register |

## Verification
Every result of this block is registered. A write in the direct modes appears on `cmp_active` one edge later. A boundary commit appears one edge after the strobe cycle. A match or a force shows on `match_flag` and `wave_out` one edge after the cycle in which the counter equals the active register. The bench applies one vector per cycle at the falling edge and reads the outputs at the next falling edge, half a period after the single rising edge that produces them. Because of this, each check sees exactly the state left by its own vector. Cases such as a compare against a register written in the same cycle, or a clear colliding with a match, are placed so that the one-edge lag decides the expected value.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

  typedef enum logic [1:0] {
    OM_HOLD   = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLEAR  = 2'b10,
    OM_SET    = 2'b11
  } outmode_e;

  // Next pin level for a compare event under a given action code
  function automatic logic pin_next(input outmode_e mode, input logic cur);
    case (mode)
      OM_TOGGLE: pin_next = ~cur;
      OM_CLEAR:  pin_next = 1'b0;
      OM_SET:    pin_next = 1'b1;
      default:   pin_next = cur;
    endcase
  endfunction

endpackage

// File: rtl/ocu_cmp_store.sv
module ocu_cmp_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwm_mode,
  input  logic         upd_at_top,
  input  logic         at_top,
  input  logic         at_bottom,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] active_o
);

  logic [W-1:0] shadow_q;
  logic [W-1:0] active_q;
  logic         boundary;

  // Boundary chosen by the counter block
  assign boundary = upd_at_top ? at_top : at_bottom;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_en) shadow_q <= wr_data;
      if (!pwm_mode) begin
        if (wr_en) active_q <= wr_data;
      end else if (boundary) begin
        active_q <= shadow_q;
      end
    end
  end

  assign active_o = active_q;

  assert_direct_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!pwm_mode && wr_en) |=> (active_q == $past(wr_data)));

  assert_no_offbound_commit_R1: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode && !(upd_at_top ? at_top : at_bottom)) |=> $stable(active_q));

  assert_only_by_write_R3: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !pwm_mode) |=> $stable(active_q));

endmodule

// File: rtl/ocu_match.sv
module ocu_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] cmp_val,
  input  logic         flag_clr,
  output logic         hit_o,
  output logic         flag_o
);

  logic flag_q;

  assign hit_o = (cnt_val == cmp_val);

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (hit_o)    flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_flag_on_match_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_val == cmp_val) |=> flag_q);

  assert_clear_wins_alone_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && (cnt_val != cmp_val)) |=> !flag_q);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q);

endmodule

// File: rtl/ocu_pin.sv
module ocu_pin
  import ocu_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pwm_mode,
  input  outmode_e out_mode,
  input  logic     hit,
  input  logic     force_cmp,
  output logic     wave_o
);

  logic wave_q;
  logic event_now;

  // A force counts as an event only outside PWM modes
  assign event_now = hit | (force_cmp & ~pwm_mode);

  always_ff @(posedge clk) begin
    if (rst)            wave_q <= 1'b0;
    else if (event_now) wave_q <= pin_next(out_mode, wave_q);
  end

  assign wave_o = wave_q;

  assert_hold_disconnected_R7: assert property (@(posedge clk) disable iff (rst)
    (out_mode == OM_HOLD) |=> $stable(wave_q));

  assert_force_ignored_pwm_R9: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode && !hit) |=> $stable(wave_q));

  assert_set_on_match_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && out_mode == OM_SET) |=> wave_q);

  assert_clear_on_match_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && out_mode == OM_CLEAR) |=> !wave_q);

  assert_force_acts_R8: assert property (@(posedge clk) disable iff (rst)
    (!pwm_mode && force_cmp && out_mode == OM_TOGGLE) |=> (wave_q != $past(wave_q)));

endmodule

// File: rtl/ocu_channel.sv
module ocu_channel
  import ocu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             at_top,
  input  logic             at_bottom,
  input  logic             upd_at_top,
  input  logic             pwm_mode,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [1:0]       out_mode,
  input  logic             force_cmp,
  input  logic             flag_clr,
  output logic             match_flag,
  output logic             wave_out,
  output logic [CNT_W-1:0] cmp_active
);

  logic [CNT_W-1:0] active_w;
  logic             hit_w;
  outmode_e         mode_w;

  assign mode_w = outmode_e'(out_mode);

  ocu_cmp_store #(.W(CNT_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .pwm_mode   (pwm_mode),
    .upd_at_top (upd_at_top),
    .at_top     (at_top),
    .at_bottom  (at_bottom),
    .wr_en      (cmp_wr),
    .wr_data    (cmp_wdata),
    .active_o   (active_w)
  );

  ocu_match #(.W(CNT_W)) u_match (
    .clk      (clk),
    .rst      (rst),
    .cnt_val  (cnt_val),
    .cmp_val  (active_w),
    .flag_clr (flag_clr),
    .hit_o    (hit_w),
    .flag_o   (match_flag)
  );

  ocu_pin u_pin (
    .clk       (clk),
    .rst       (rst),
    .pwm_mode  (pwm_mode),
    .out_mode  (mode_w),
    .hit       (hit_w),
    .force_cmp (force_cmp),
    .wave_o    (wave_out)
  );

  assign cmp_active = active_w;

  assert_force_no_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (!match_flag && force_cmp && (cnt_val != cmp_active)) |=> !match_flag);

endmodule

// File: tb/test_ocu_channel.sv
module test_ocu_channel;

  localparam int W = 16;
  localparam logic [W-1:0] IDLE = 16'h7777;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] cnt_val;
  logic         at_top, at_bottom, upd_at_top, pwm_mode;
  logic         cmp_wr;
  logic [W-1:0] cmp_wdata;
  logic [1:0]   out_mode;
  logic         force_cmp, flag_clr;
  logic         match_flag, wave_out;
  logic [W-1:0] cmp_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ocu_channel #(.CNT_W(W)) i_ocu_channel (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .at_top(at_top),
    .at_bottom(at_bottom), .upd_at_top(upd_at_top), .pwm_mode(pwm_mode),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .out_mode(out_mode),
    .force_cmp(force_cmp), .flag_clr(flag_clr), .match_flag(match_flag),
    .wave_out(wave_out), .cmp_active(cmp_active)
  );

  typedef struct packed {
    logic        pwm;
    logic        wr;
    logic [15:0] wdata;
    logic [15:0] cnt;
    logic        top;
    logic        bot;
    logic        utop;
    logic [1:0]  mode;
    logic        frc;
    logic        clr;
    logic        eflag;
    logic        ewave;
    logic [15:0] eact;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  // pwm wr wdata cnt top bot utop mode frc clr | eflag ewave eact | req
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,16'h0100,16'h7777,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,1'b0,16'h0100, 8'd2},  // R2 direct write
    '{1'b0,1'b0,16'h0000,16'h0100,1'b0,1'b0,1'b0,2'b11,1'b0,1'b0, 1'b1,1'b1,16'h0100, 8'd6},  // R4 R6 set
    '{1'b0,1'b0,16'h0000,16'h7777,1'b0,1'b0,1'b0,2'b11,1'b0,1'b1, 1'b0,1'b1,16'h0100, 8'd5},  // R5 clear
    '{1'b0,1'b0,16'h0000,16'h0100,1'b0,1'b0,1'b0,2'b10,1'b0,1'b1, 1'b1,1'b0,16'h0100, 8'd5},  // R5 match wins, R6 clear
    '{1'b0,1'b0,16'h0000,16'h0100,1'b0,1'b0,1'b0,2'b01,1'b0,1'b0, 1'b1,1'b1,16'h0100, 8'd6},  // R6 toggle
    '{1'b0,1'b0,16'h0000,16'h0100,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b1,1'b1,16'h0100, 8'd7},  // R7 hold on match
    '{1'b0,1'b0,16'h0000,16'h0100,1'b0,1'b0,1'b0,2'b01,1'b0,1'b1, 1'b1,1'b0,16'h0100, 8'd6},  // R6 toggle back
    '{1'b0,1'b0,16'h0000,16'h7777,1'b0,1'b0,1'b0,2'b11,1'b0,1'b1, 1'b0,1'b0,16'h0100, 8'd5},  // R5 clear
    '{1'b0,1'b0,16'h0000,16'h7777,1'b0,1'b0,1'b0,2'b11,1'b1,1'b0, 1'b0,1'b1,16'h0100, 8'd8},  // R8 force set, no flag
    '{1'b0,1'b0,16'h0000,16'h7777,1'b0,1'b0,1'b0,2'b01,1'b1,1'b0, 1'b0,1'b0,16'h0100, 8'd8},  // R8 force toggle
    '{1'b1,1'b1,16'h0200,16'h7777,1'b0,1'b0,1'b1,2'b11,1'b0,1'b0, 1'b0,1'b0,16'h0100, 8'd1},  // R1 buffered
    '{1'b1,1'b0,16'h0000,16'h7777,1'b0,1'b0,1'b1,2'b11,1'b1,1'b0, 1'b0,1'b0,16'h0100, 8'd9},  // R9 force ignored
    '{1'b1,1'b0,16'h0000,16'h7777,1'b0,1'b1,1'b1,2'b00,1'b0,1'b0, 1'b0,1'b0,16'h0100, 8'd1},  // R1 wrong strobe
    '{1'b1,1'b0,16'h0000,16'h7777,1'b1,1'b0,1'b1,2'b00,1'b0,1'b0, 1'b0,1'b0,16'h0200, 8'd1},  // R1 commit at TOP
    '{1'b1,1'b1,16'h0300,16'h7777,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,1'b0,16'h0200, 8'd1},  // R1 buffered
    '{1'b1,1'b0,16'h0000,16'h7777,1'b1,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,1'b0,16'h0200, 8'd1},  // R1 wrong strobe
    '{1'b1,1'b0,16'h0000,16'h7777,1'b0,1'b1,1'b0,2'b00,1'b0,1'b0, 1'b0,1'b0,16'h0300, 8'd1},  // R1 commit at BOTTOM
    '{1'b1,1'b0,16'h0000,16'h0300,1'b0,1'b0,1'b0,2'b11,1'b0,1'b0, 1'b1,1'b1,16'h0300, 8'd4},  // R4 match in PWM
    '{1'b0,1'b0,16'h0000,16'h7777,1'b1,1'b1,1'b0,2'b00,1'b0,1'b1, 1'b0,1'b1,16'h0300, 8'd3},  // R3 strobes no effect
    '{1'b0,1'b1,16'hFFFF,16'hFFFF,1'b0,1'b0,1'b0,2'b10,1'b0,1'b0, 1'b0,1'b1,16'hFFFF, 8'd4},  // R4 old value compared
    '{1'b0,1'b0,16'h0000,16'hFFFF,1'b0,1'b0,1'b0,2'b10,1'b0,1'b0, 1'b1,1'b0,16'hFFFF, 8'd4},  // R4 all-ones match
    '{1'b1,1'b0,16'h0000,16'h7777,1'b0,1'b1,1'b0,2'b00,1'b0,1'b1, 1'b0,1'b0,16'hFFFF, 8'd2}   // R2 buffer mirrored
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cnt_val = IDLE; at_top = 0; at_bottom = 0; upd_at_top = 0; pwm_mode = 0;
    cmp_wr = 0; cmp_wdata = '0; out_mode = 2'b00; force_cmp = 0; flag_clr = 0;
  endtask

  initial begin
    rst = 1'b1;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 flag", {15'b0, match_flag}, 16'h0);
    chk("R10 wave", {15'b0, wave_out}, 16'h0);
    chk("R10 active", cmp_active, 16'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      pwm_mode = TBL[i].pwm;  cmp_wr = TBL[i].wr;  cmp_wdata = TBL[i].wdata;
      cnt_val = TBL[i].cnt;   at_top = TBL[i].top; at_bottom = TBL[i].bot;
      upd_at_top = TBL[i].utop; out_mode = TBL[i].mode;
      force_cmp = TBL[i].frc; flag_clr = TBL[i].clr;
      @(negedge clk);
      chk($sformatf("R%0d v%0d flag", TBL[i].req, i), {15'b0, match_flag}, {15'b0, TBL[i].eflag});
      chk($sformatf("R%0d v%0d wave", TBL[i].req, i), {15'b0, wave_out}, {15'b0, TBL[i].ewave});
      chk($sformatf("R%0d v%0d active", TBL[i].req, i), cmp_active, TBL[i].eact);
    end
    idle_inputs();

    // R9: toggle force in PWM with wave high, pin must stay
    pwm_mode = 1; out_mode = 2'b11; cnt_val = 16'hFFFF;
    @(negedge clk);
    chk("R9 setup wave", {15'b0, wave_out}, 16'h1);
    cnt_val = IDLE; out_mode = 2'b01; force_cmp = 1;
    @(negedge clk);
    chk("R9 force ignored", {15'b0, wave_out}, 16'h1);
    // R8: flag untouched by force after clear
    pwm_mode = 0; force_cmp = 1; flag_clr = 1; out_mode = 2'b10;
    @(negedge clk);
    chk("R8 force clears pin", {15'b0, wave_out}, 16'h0);
    chk("R8 flag cleared not set", {15'b0, match_flag}, 16'h0);
    idle_inputs();

    // R10: mid-run reset
    out_mode = 2'b11; cnt_val = 16'hFFFF;
    @(negedge clk);
    rst = 1'b1; cnt_val = IDLE;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 rerun flag", {15'b0, match_flag}, 16'h0);
    chk("R10 rerun wave", {15'b0, wave_out}, 16'h0);
    chk("R10 rerun active", cmp_active, 16'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule